// File: doc/BRIEF.md
# Low-Power Escape Receiver for Lane Zero

This block sits on the receiving end of a display link's first data lane while that lane is in its low-power, single-ended signalling mode. A system clock runs much faster than the low-power bit rate, and the block uses it to sample the two line levels. It waits on the idle level and recognises the multi-step entry pattern into escape mode. Inside escape mode it decodes the spaced one-hot bit code, using the exclusive-OR of the two lines as the recovered bit clock, and assembles bytes least significant bit first.

The first byte after entry is the escape command. It is reported together with a one-cycle strobe. When the command selects low-power data reception, every later complete byte appears on a data output with its own one-cycle strobe. The exit pattern returns the block to idle and drops any byte that is only partly received. A level that does not fit the protocol produces a one-cycle error pulse and sends the decoder back to idle.

In the requirements, line levels are written as LP-pn, where p is `lp_p` and n is `lp_n`.

Top module: `lp_esc_rx`

## Requirements
- R1: While reset is high and after it is released, `in_escape`, `cmd_valid`, `rx_valid` and `err` are 0, and `cmd_byte` and `rx_byte` are 0.
- R2: Each line passes through two synchronizer flops. A new line level is accepted only after it has been sampled the same on two consecutive clocks, so a level that lasts a single clock is ignored.
- R3: Escape mode begins only after the full accepted sequence LP-11, LP-10, LP-00, LP-01, LP-00. If the line leaves LP-11 for any level other than LP-10, the block raises no error and waits for LP-11 again.
- R4: The recovered clock is the XOR of the two lines. A bit is taken each time that clock falls into LP-00: after LP-01 the bit is 1, and after LP-10 it is 0.
- R5: The first 8 bits after entry form `cmd_byte`, with the first bit received in bit 0. The command is reported with a one-cycle `cmd_valid` pulse.
- R6: If the command equals 0xE1, each following group of 8 bits is delivered on `rx_byte`, first bit in bit 0, with a one-cycle `rx_valid` pulse.
- R7: Any other command value delivers no data bytes before the exit.
- R8: LP-01 followed by LP-11 inside escape mode clears `in_escape` without an error.
- R9: Bits of a byte that is still incomplete at exit are discarded, and no `rx_valid` pulse is issued for them.
- R10: Any other level change during entry or during escape mode (for example LP-11 after LP-10, or LP-01 straight after LP-10) pulses `err` for one cycle and clears `in_escape`. A new escape needs LP-11 and then the full entry sequence.
- R11: Each output result appears on the fifth rising clock edge after the input change that completes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_p | input | 1 | Positive line level, asynchronous |
| lp_n | input | 1 | Negative line level, asynchronous |
| cmd_byte | output | BYTE_W | Last escape command received |
| cmd_valid | output | 1 | One-cycle strobe for `cmd_byte` |
| rx_byte | output | BYTE_W | Last data byte received |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| in_escape | output | 1 | High while escape mode is active |
| err | output | 1 | One-cycle protocol error pulse |

## Verification
A line change takes one edge in each synchronizer flop and one edge in the stability compare before it is accepted. The decoder and assembler register their results on the next edge, so `in_escape`, the strobes and `err` are due on the fifth edge. One directed case drives the last entry level just after a falling edge and checks `in_escape` at the falling edge after the fourth rising edge, where it must still be low, and again after the fifth, where it must be high. Every other stimulus holds each level for six clocks and then allows a settling margin, and a monitor samples the outputs on falling edges. As a result, all pulses are collected before the counts and byte values are compared against the bench's own model.

// File: rtl/lp_esc_pkg.sv
package lp_esc_pkg;
  typedef logic [1:0] lp_lvl_t;  // {p, n}
  localparam lp_lvl_t LP_00 = 2'b00;
  localparam lp_lvl_t LP_01 = 2'b01;
  localparam lp_lvl_t LP_10 = 2'b10;
  localparam lp_lvl_t LP_11 = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_ENT_A, ST_ENT_B, ST_ENT_C,
    ST_SPACE, ST_MARK1, ST_MARK0
  } esc_st_t;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_SKIP} byte_ph_t;
endpackage

// File: rtl/lp_line_sync.sv
module lp_line_sync
  import lp_esc_pkg::*;
#(
  parameter int STABLE_N = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    lp_p,
  input  logic    lp_n,
  output lp_lvl_t line_q,
  output logic    line_evt
);
  localparam int CW = $clog2(STABLE_N) + 1;
  localparam logic [CW-1:0] CMAX = CW'(STABLE_N - 1);

  lp_lvl_t meta_q, sync_q, prev_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic accept;

  always_comb begin
    if (sync_q == prev_q) cnt_nx = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
    else                  cnt_nx = '0;
    accept = (cnt_nx == CMAX) && (sync_q != line_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= LP_11;
      sync_q   <= LP_11;
      prev_q   <= LP_11;
      cnt_q    <= '0;
      line_q   <= LP_11;
      line_evt <= 1'b0;
    end else begin
      meta_q   <= {lp_p, lp_n};
      sync_q   <= meta_q;
      prev_q   <= sync_q;
      cnt_q    <= cnt_nx;
      line_evt <= accept;
      if (accept) line_q <= sync_q;
    end
  end

  // R2
  stable_accept_chk: assert property (@(posedge clk) disable iff (rst)
    line_evt |-> (line_q == $past(sync_q)) && (line_q == $past(sync_q, 2)));
endmodule

// File: rtl/lp_esc_fsm.sv
module lp_esc_fsm
  import lp_esc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  lp_lvl_t line_q,
  input  logic    line_evt,
  output logic    bit_stb,
  output logic    bit_val,
  output logic    esc_start,
  output logic    in_escape,
  output logic    err
);
  esc_st_t st_q, st_nx;
  logic fault, leave, clk_rec;

  assign clk_rec = line_q[1] ^ line_q[0];

  always_comb begin
    st_nx     = st_q;
    bit_stb   = 1'b0;
    bit_val   = 1'b0;
    esc_start = 1'b0;
    fault     = 1'b0;
    leave     = 1'b0;
    if (line_evt) begin
      case (st_q)
        ST_IDLE:  st_nx = (line_q == LP_10) ? ST_ENT_A : ST_HOLD;
        ST_HOLD:  if (line_q == LP_11) st_nx = ST_IDLE;
        ST_ENT_A: if (line_q == LP_00) st_nx = ST_ENT_B; else fault = 1'b1;
        ST_ENT_B: if (line_q == LP_01) st_nx = ST_ENT_C; else fault = 1'b1;
        ST_ENT_C: if (line_q == LP_00) begin
                    st_nx = ST_SPACE;
                    esc_start = 1'b1;
                  end else fault = 1'b1;
        ST_SPACE: if (line_q == LP_01)      st_nx = ST_MARK1;
                  else if (line_q == LP_10) st_nx = ST_MARK0;
                  else fault = 1'b1;
        ST_MARK1: if (!clk_rec && line_q == LP_00) begin
                    bit_stb = 1'b1;
                    bit_val = 1'b1;
                    st_nx   = ST_SPACE;
                  end else if (line_q == LP_11) begin
                    leave = 1'b1;
                    st_nx = ST_IDLE;
                  end else fault = 1'b1;
        ST_MARK0: if (!clk_rec && line_q == LP_00) begin
                    bit_stb = 1'b1;
                    st_nx   = ST_SPACE;
                  end else fault = 1'b1;
        default:  st_nx = ST_IDLE;
      endcase
      if (fault) st_nx = (line_q == LP_11) ? ST_IDLE : ST_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      in_escape <= 1'b0;
      err       <= 1'b0;
    end else begin
      st_q <= st_nx;
      err  <= fault;
      if (esc_start)           in_escape <= 1'b1;
      else if (leave || fault) in_escape <= 1'b0;
    end
  end

  // R3
  entry_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_escape) |-> (line_q == LP_00));
  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  // R10
  err_clears_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !in_escape);
  // R8
  exit_level_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(in_escape) && !err) |-> (line_q == LP_11));
endmodule

// File: rtl/lp_byte_asm.sv
module lp_byte_asm
  import lp_esc_pkg::*;
#(
  parameter int                BYTE_W = 8,
  parameter logic [BYTE_W-1:0] CMD_RX = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              esc_start,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, full;
  logic [CNT_W-1:0]  cnt_q;
  byte_ph_t          ph_q;

  assign full = {bit_val, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      ph_q      <= PH_CMD;
      cmd_byte  <= '0;
      cmd_valid <= 1'b0;
      rx_byte   <= '0;
      rx_valid  <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      rx_valid  <= 1'b0;
      if (esc_start) begin
        sh_q  <= '0;
        cnt_q <= '0;
        ph_q  <= PH_CMD;
      end else if (bit_stb) begin
        sh_q <= full;
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          case (ph_q)
            PH_CMD: begin
              cmd_byte  <= full;
              cmd_valid <= 1'b1;
              ph_q      <= (full == CMD_RX) ? PH_DATA : PH_SKIP;
            end
            PH_DATA: begin
              rx_byte  <= full;
              rx_valid <= 1'b1;
            end
            default: ;
          endcase
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7
  skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_SKIP) |-> !rx_valid);
endmodule

// File: rtl/lp_esc_rx.sv
module lp_esc_rx
  import lp_esc_pkg::*;
#(
  parameter int                STABLE_N = 2,
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] CMD_RX   = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_p,
  input  logic              lp_n,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              in_escape,
  output logic              err
);
  lp_lvl_t line_q;
  logic line_evt, bit_stb, bit_val, esc_start;

  lp_line_sync #(.STABLE_N(STABLE_N)) u_sync (
    .clk(clk), .rst(rst), .lp_p(lp_p), .lp_n(lp_n),
    .line_q(line_q), .line_evt(line_evt)
  );

  lp_esc_fsm u_fsm (
    .clk(clk), .rst(rst), .line_q(line_q), .line_evt(line_evt),
    .bit_stb(bit_stb), .bit_val(bit_val), .esc_start(esc_start),
    .in_escape(in_escape), .err(err)
  );

  lp_byte_asm #(.BYTE_W(BYTE_W), .CMD_RX(CMD_RX)) u_asm (
    .clk(clk), .rst(rst), .esc_start(esc_start),
    .bit_stb(bit_stb), .bit_val(bit_val),
    .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  // R6
  rx_in_esc_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> in_escape);
  // R5
  cmd_in_esc_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> in_escape);
endmodule

// File: tb/lp_esc_rx_tb.sv
module lp_esc_rx_tb;
  localparam int HOLD = 6;
  logic clk = 1'b0, rst = 1'b1, lp_p = 1'b1, lp_n = 1'b1;
  logic [7:0] cmd_byte, rx_byte;
  logic cmd_valid, rx_valid, in_escape, err;

  lp_esc_rx u_dut (
    .clk(clk), .rst(rst), .lp_p(lp_p), .lp_n(lp_n),
    .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
    .rx_byte(rx_byte), .rx_valid(rx_valid),
    .in_escape(in_escape), .err(err)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int cmd_n = 0, rx_n = 0, err_n = 0;
  logic [7:0] last_cmd = 8'h00;
  logic [7:0] rx_log [0:255];
  bit done = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid) begin cmd_n++; last_cmd = cmd_byte; end
      if (rx_valid) begin
        if (rx_n < 256) rx_log[rx_n] = rx_byte;
        rx_n++;
      end
      if (err) err_n++;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lvl(logic [1:0] v);
    @(negedge clk);
    {lp_p, lp_n} = v;
    repeat (HOLD - 1) @(negedge clk);
  endtask

  task automatic entry_tx();
    lvl(2'b10); lvl(2'b00); lvl(2'b01); lvl(2'b00);
  endtask

  task automatic bit_tx(bit b);  // R4: 01/00 is one, 10/00 is zero
    lvl(b ? 2'b01 : 2'b10);
    lvl(2'b00);
  endtask

  task automatic byte_tx(logic [7:0] x);
    for (int i = 0; i < 8; i++) bit_tx(x[i]);
  endtask

  task automatic exit_tx();
    lvl(2'b01); lvl(2'b11);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    int c0, r0, e0;
    seed_v = $urandom(32'd7741);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 in_escape", int'(in_escape), 0);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 cmd_byte", int'(cmd_byte), 0);
    chk("R1 rx_byte", int'(rx_byte), 0);

    // R11 / R3: in_escape due on 5th edge after the final LP-00
    lvl(2'b10); lvl(2'b00); lvl(2'b01);
    @(negedge clk);
    {lp_p, lp_n} = 2'b00;
    repeat (4) @(negedge clk);
    chk("R11 in_escape before 5th edge", int'(in_escape), 0);
    @(negedge clk);
    chk("R11 R3 in_escape on 5th edge", int'(in_escape), 1);
    repeat (HOLD) @(negedge clk);

    // R5 R6 R2: 0xE1 command, data, one-clock glitch ignored
    byte_tx(8'hE1);
    byte_tx(8'h3C);
    @(negedge clk); {lp_p, lp_n} = 2'b01;
    @(negedge clk); {lp_p, lp_n} = 2'b00;
    repeat (HOLD) @(negedge clk);
    byte_tx(8'hC3);
    exit_tx();
    chk("R5 cmd count", cmd_n, 1);
    chk("R5 cmd value", int'(last_cmd), 'hE1);
    chk("R6 R2 rx count", rx_n, 2);
    chk("R6 R4 byte0", int'(rx_log[0]), 'h3C);
    chk("R2 byte1 after glitch", int'(rx_log[1]), 'hC3);
    chk("R8 in_escape cleared", int'(in_escape), 0);
    chk("R8 no err on exit", err_n, 0);

    // R7 foreign command
    c0 = cmd_n; r0 = rx_n; e0 = err_n;
    entry_tx(); byte_tx(8'h87); byte_tx(8'h55); byte_tx(8'hAA); exit_tx();
    chk("R7 cmd count", cmd_n, c0 + 1);
    chk("R7 cmd value", int'(last_cmd), 'h87);
    chk("R7 no data", rx_n, r0);
    chk("R7 no err", err_n, e0);

    // R9 partial byte dropped
    r0 = rx_n; e0 = err_n;
    entry_tx(); byte_tx(8'hE1); byte_tx(8'h5A);
    bit_tx(1); bit_tx(0); bit_tx(1);
    exit_tx();
    chk("R9 rx count", rx_n, r0 + 1);
    chk("R9 byte", int'(rx_log[r0]), 'h5A);
    chk("R9 no err", err_n, e0);

    // R8 exit right after entry
    c0 = cmd_n; e0 = err_n;
    entry_tx(); exit_tx();
    chk("R8 empty escape no cmd", cmd_n, c0);
    chk("R8 empty escape no err", err_n, e0);
    chk("R8 empty escape left", int'(in_escape), 0);

    // R10 LP-11 inside a zero bit, then recovery
    r0 = rx_n; e0 = err_n;
    entry_tx(); byte_tx(8'hE1); bit_tx(1);
    lvl(2'b10); lvl(2'b11);
    repeat (8) @(negedge clk);
    chk("R10 err pulse", err_n, e0 + 1);
    chk("R10 in_escape cleared", int'(in_escape), 0);
    chk("R10 no data", rx_n, r0);
    entry_tx(); byte_tx(8'hE1); byte_tx(8'h99); exit_tx();
    chk("R10 recovery count", rx_n, r0 + 1);
    chk("R10 recovery byte", int'(rx_log[r0]), 'h99);

    // R10 broken entry
    c0 = cmd_n; e0 = err_n;
    lvl(2'b10); lvl(2'b01); lvl(2'b00); lvl(2'b11);
    repeat (8) @(negedge clk);
    chk("R10 broken entry err", err_n, e0 + 1);
    chk("R10 broken entry idle", int'(in_escape), 0);

    // R3 other departures from idle are silent
    e0 = err_n;
    lvl(2'b01); lvl(2'b00); lvl(2'b11);
    repeat (8) @(negedge clk);
    chk("R3 no err", err_n, e0);
    chk("R3 no escape", int'(in_escape), 0);
    chk("R3 no cmd", cmd_n, c0);

    // random frames
    for (int f = 0; f < 20; f++) begin
      logic [7:0] cmd_v;
      logic [7:0] dat [0:3];
      int nb, np;
      nb = int'($urandom_range(0, 4));
      np = int'($urandom_range(0, 7));
      cmd_v = 8'hE1;
      if ($urandom_range(0, 3) == 0) begin
        cmd_v = 8'($urandom);
        if (cmd_v == 8'hE1) cmd_v = 8'hE0;
      end
      for (int i = 0; i < 4; i++) dat[i] = 8'($urandom);
      c0 = cmd_n; r0 = rx_n; e0 = err_n;
      entry_tx();
      byte_tx(cmd_v);
      for (int i = 0; i < nb; i++) byte_tx(dat[i]);
      for (int i = 0; i < np; i++) bit_tx(1'($urandom));
      exit_tx();
      chk("R5 rand cmd count", cmd_n, c0 + 1);
      chk("R5 rand cmd value", int'(last_cmd), int'(cmd_v));
      chk("R6 R7 R9 rand rx count", rx_n, r0 + ((cmd_v == 8'hE1) ? nb : 0));
      if (cmd_v == 8'hE1 && rx_n == r0 + nb)
        for (int i = 0; i < nb; i++)
          chk("R6 rand byte", int'(rx_log[r0 + i]), int'(dat[i]));
      chk("R8 rand no err", err_n, e0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule